// File: doc/BRIEF.md
# Cyclic DAC Waveform FIFO Controller

This block feeds a DAC output register from a sample buffer. The host pushes waveform samples through a write port. Each pulse from an external update timer moves one stored sample to the DAC register and raises a one-cycle strobe. The buffer holds up to `DEPTH` samples, which is 2,048 by default.

There are two modes. In streaming mode the host keeps refilling the buffer. A data-request output tells the host when there is room for more samples. In cyclic mode the host loads a complete waveform once after a buffer clear. The block then replays it indefinitely by rewinding its read position at the end of the stored data, and asks the host for nothing. A stop control makes replay finish the pass in progress and halt at the end of the buffer, with a done flag raised.

If an update pulse finds the buffer empty, the block stops driving the DAC by itself and latches an error flag. The flag stays set until the host clears it.

Top module: `cyclic_dac_fifo`

## Requirements
- R1: After reset `dac_strobe`, `underflow_err` and `cyclic_done` are 0, `dac_data` is 0 and `fifo_empty` is 1.
- R2: In streaming mode, each update pulse accepted while the buffer holds data loads the oldest unread sample into `dac_data` at the next clock edge. `dac_strobe` is 1 for exactly that one cycle. Samples leave in write order.
- R3: `fifo_full` is 1 when `DEPTH` unread samples are stored. A write while full is dropped and changes no stored sample.
- R4: In streaming mode (`cyclic_mode`=0), `data_req` is 1 while the number of unread samples is at most `DEPTH/2` and 0 above that. In cyclic mode `data_req` is always 0.
- R5: An update pulse that arrives while output is enabled and the buffer is empty sets `underflow_err` at the next edge. It gives no strobe and leaves `dac_data` unchanged.
- R6: `underflow_err` stays set until `err_clr` is pulsed. While it is set, update pulses give no strobe and consume no sample. After the clear, the next pulse delivers the oldest unread sample.
- R7: In cyclic mode, the pulse after the one that delivered the last sample written since the last `fifo_clr` delivers the first stored sample again. Replay does not consume data and never underflows.
- R8: In cyclic mode with `cyclic_stop`=1, the pass in progress completes. `cyclic_done` becomes 1 at the edge that delivers the last stored sample. After that, pulses give no strobe until `fifo_clr` or `err_clr`.
- R9: While `out_enable`=0, update pulses give no strobe and consume no sample.
- R10: `fifo_clr` discards all stored samples, so `fifo_empty` becomes 1, and it clears `cyclic_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host sample write strobe |
| wr_data | input | DW | Host sample value |
| fifo_clr | input | 1 | Discard buffer contents and rewind both positions |
| cyclic_mode | input | 1 | 1 = replay stored waveform, 0 = streaming |
| cyclic_stop | input | 1 | End cyclic replay at the buffer end |
| out_enable | input | 1 | Allow update pulses to drive the DAC |
| err_clr | input | 1 | Clear underflow error and done flag |
| update_pulse | input | 1 | One-cycle timer pulse requesting a DAC update |
| dac_data | output | DW | Sample held in the DAC register |
| dac_strobe | output | 1 | One-cycle pulse when `dac_data` is loaded |
| data_req | output | 1 | Streaming-mode request for more samples |
| underflow_err | output | 1 | Latched underflow error |
| cyclic_done | output | 1 | Cyclic replay halted at the buffer end |
| fifo_full | output | 1 | Buffer holds `DEPTH` unread samples |
| fifo_empty | output | 1 | No unread sample remains |

## Verification
The assertions assume that `update_pulse`, `fifo_clr` and `err_clr` are single-cycle pulses. They also assume that `cyclic_mode` changes only while the buffer is cleared, and that a cyclic waveform is loaded after a `fifo_clr` with no more than `DEPTH` samples. The bench switches modes only next to a `fifo_clr`. It never overfills a cyclic load, and it drives every control pulse for exactly one cycle, away from the active edge. Underflow, disable and stop are each entered on purpose so that the checked pulse-ignoring paths are really exercised.

// File: rtl/cyclic_dac_fifo.sv
module cyclic_dac_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          fifo_clr,
  input  logic          cyclic_mode,
  input  logic          cyclic_stop,
  input  logic          out_enable,
  input  logic          err_clr,
  input  logic          update_pulse,
  output logic [DW-1:0] dac_data,
  output logic          dac_strobe,
  output logic          data_req,
  output logic          underflow_err,
  output logic          cyclic_done,
  output logic          fifo_full,
  output logic          fifo_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_ptr, rd_ptr;
  logic          err_q, done_q;

  wire [CW-1:0] level  = wr_ptr - rd_ptr;
  wire          halted = err_q | done_q | ~out_enable;
  wire          take   = update_pulse & ~halted & ~fifo_clr;
  wire          starve = take & fifo_empty;
  wire          fire   = take & ~fifo_empty;
  wire          at_end = cyclic_mode & (rd_ptr + CW'(1) == wr_ptr);
  wire          wr_ok  = wr_en & ~fifo_full & ~fifo_clr;

  assign fifo_full     = (level == FULL_CNT);
  assign fifo_empty    = (level == '0);
  assign data_req      = ~cyclic_mode & (level <= HALF_CNT);
  assign underflow_err = err_q;
  assign cyclic_done   = done_q;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + CW'(1);
      if (fire) begin
        if (at_end && !cyclic_stop) rd_ptr <= '0;
        else                        rd_ptr <= rd_ptr + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (starve)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (fifo_clr || err_clr)               done_q <= 1'b0;
      else if (fire && at_end && cyclic_stop) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data   <= '0;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= fire;
      if (fire) dac_data <= mem[rd_ptr[AW-1:0]];
    end
  end
endmodule

module cyclic_dac_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic fifo_clr,
  input logic cyclic_mode,
  input logic out_enable,
  input logic err_clr,
  input logic update_pulse,
  input logic dac_strobe,
  input logic data_req,
  input logic underflow_err,
  input logic cyclic_done,
  input logic fifo_full,
  input logic fifo_empty
);
  p_strobe_from_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(update_pulse));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && wr_en && !update_pulse && !fifo_clr |=> fifo_full);

  p_no_req_cyclic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyclic_mode |-> !data_req);

  p_underflow_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse && out_enable && fifo_empty && !underflow_err && !cyclic_done && !fifo_clr
    |=> underflow_err && !dac_strobe);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err && !err_clr |=> underflow_err);

  p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> !dac_strobe);

  p_cyclic_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyclic_mode && !fifo_empty && !underflow_err |=> !underflow_err);

  p_done_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyclic_done && !err_clr && !fifo_clr |=> cyclic_done && !dac_strobe);

  p_disable_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_enable |=> !dac_strobe);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> fifo_empty && !cyclic_done);
endmodule

bind cyclic_dac_fifo cyclic_dac_fifo_chk u_chk (.*);

// File: tb/cyclic_dac_fifo_test.sv
module cyclic_dac_fifo_test;
  localparam int DW = 12;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, fifo_clr = 1'b0, cyclic_mode = 1'b0, cyclic_stop = 1'b0;
  logic out_enable = 1'b1, err_clr = 1'b0, update_pulse = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dac_data;
  logic dac_strobe, data_req, underflow_err, cyclic_done, fifo_full, fifo_empty;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cyclic_dac_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
    .cyclic_mode(cyclic_mode), .cyclic_stop(cyclic_stop), .out_enable(out_enable),
    .err_clr(err_clr), .update_pulse(update_pulse), .dac_data(dac_data),
    .dac_strobe(dac_strobe), .data_req(data_req), .underflow_err(underflow_err),
    .cyclic_done(cyclic_done), .fifo_full(fifo_full), .fifo_empty(fifo_empty));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input int d);
    wr_en = 1'b1; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    update_pulse = 1'b1;
    @(negedge clk);
    update_pulse = 1'b0;
  endtask

  task automatic clear();
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic clr_err();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 strobe", dac_strobe, 0);
    check("R1 err", underflow_err, 0);
    check("R1 done", cyclic_done, 0);
    check("R1 data", dac_data, 0);
    check("R1 empty", fifo_empty, 1);
  endtask

  task automatic t_stream_underflow();
    for (int i = 0; i < 5; i++) write(100 + i);
    for (int i = 0; i < 5; i++) begin
      pulse();
      check("R2 strobe", dac_strobe, 1);
      check("R2 data", dac_data, 100 + i);
      @(negedge clk);
      check("R2 strobe one cycle", dac_strobe, 0);
    end
    pulse();
    check("R5 err set", underflow_err, 1);
    check("R5 no strobe", dac_strobe, 0);
    check("R5 data held", dac_data, 104);
    write(7);
    pulse();
    check("R6 no strobe while err", dac_strobe, 0);
    check("R6 err sticky", underflow_err, 1);
    clr_err();
    check("R6 err cleared", underflow_err, 0);
    pulse();
    check("R6 sample kept", dac_data, 7);
    check("R6 strobe after clear", dac_strobe, 1);
  endtask

  task automatic t_request();
    clear();
    for (int i = 0; i < DEPTH / 2; i++) write(i);
    check("R4 req at half", data_req, 1);
    write(99);
    check("R4 req above half", data_req, 0);
    clear();
    cyclic_mode = 1'b1;
    @(negedge clk);
    check("R4 no req cyclic", data_req, 0);
    cyclic_mode = 1'b0;
    clear();
  endtask

  task automatic t_full();
    clear();
    for (int i = 0; i < DEPTH; i++) write(200 + i);
    check("R3 full", fifo_full, 1);
    write(999);
    for (int i = 0; i < DEPTH; i++) begin
      pulse();
      check("R3 order", dac_data, 200 + i);
    end
    check("R3 extra dropped", fifo_empty, 1);
  endtask

  task automatic t_disable();
    clear();
    write(300); write(301);
    out_enable = 1'b0;
    pulse();
    check("R9 no strobe", dac_strobe, 0);
    out_enable = 1'b1;
    pulse();
    check("R9 no consume", dac_data, 300);
  endtask

  task automatic t_cyclic();
    clear();
    cyclic_mode = 1'b1;
    write(500); write(501); write(502);
    for (int i = 0; i < 7; i++) begin
      pulse();
      check("R7 replay", dac_data, 500 + (i % 3));
      check("R7 strobe", dac_strobe, 1);
    end
    check("R7 no underflow", underflow_err, 0);
    cyclic_stop = 1'b1;
    pulse();
    check("R8 finish pass", dac_data, 501);
    check("R8 not done yet", cyclic_done, 0);
    pulse();
    check("R8 last sample", dac_data, 502);
    check("R8 done", cyclic_done, 1);
    pulse();
    check("R8 halted", dac_strobe, 0);
    check("R8 data held", dac_data, 502);
    clear();
    check("R10 done cleared", cyclic_done, 0);
    check("R10 empty", fifo_empty, 1);
    cyclic_stop = 1'b0;
    cyclic_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_stream_underflow();
    t_request();
    t_full();
    t_disable();
    t_cyclic();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule